// File: doc/BRIEF.md
# H-bridge switch command controller

This block turns two direction bits, a PWM bit and two per-leg enable lines into on/off commands for the four switches of a full bridge: a high-side and a low-side switch on leg A, and the same pair on leg B. The direction bits pick one of four operating modes. PWM modulates only the low-side switches. Whenever the requested mode changes, the block holds every switch off for a programmable number of clock cycles before it applies the new mode.

Each leg has a fault latch. The latch is set by that leg's high-side overtemperature flag or its low-side overcurrent flag. While the latch is set, the leg stays off and the block asserts a pull-down request on that leg's shared enable/diagnostic line. The latch clears only on a low-to-high transition of the leg's own direction bit. A supply-out-of-range flag turns all four switches off while it is asserted. A current-sense enable is high only in the two driving modes, and only while the sense-disable input is low.

Top module: `hbridge_ctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, all four switch commands, both diagnostic pull-downs and the sense enable are 0.
- R2: The mode is {dir_a, dir_b}. The switch patterns are:
  - 11: both high-side switches on.
  - 10: high-side A and low-side B on.
  - 01: high-side B and low-side A on.
  - 00: both low-side switches on.
- R3: When the synchronized PWM bit is 0, both low-side commands are 0 in every mode. The high-side commands do not depend on PWM.
- R4: An enable line held at 0 turns off both switches of its own leg and leaves the other leg unchanged.
- R5: A high-side or low-side fault flag on a leg, sampled at a clock edge, latches that leg off and raises that leg's diagnostic pull-down from that edge onwards. The other leg is unaffected.
- R6: A latched fault stays set when its flag drops and when its direction bit falls. It clears only on a rising edge of that leg's direction bit.
- R7: A change of mode at the inputs forces all switches and the sense enable to 0 from the third clock edge after the change. The new pattern appears at edge dead_ticks+4, counting the edge that first samples the change as edge 1.
- R8: sense_en is 1 only in modes 10 and 01, when no mode change is pending and sense_dis is 0.
- R9: supply_bad sampled at an edge turns all four switch commands off from that edge until an edge that samples it low.
- R10: The high-side and low-side commands of the same leg are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| dir_a | input | 1 | direction bit of leg A |
| dir_b | input | 1 | direction bit of leg B |
| pwm_in | input | 1 | PWM for the low-side switches |
| en_a_in | input | 1 | level sensed on leg A enable/diagnostic line |
| en_b_in | input | 1 | level sensed on leg B enable/diagnostic line |
| hs_fault_a | input | 1 | high-side overtemperature flag, leg A |
| ls_fault_a | input | 1 | low-side overcurrent flag, leg A |
| hs_fault_b | input | 1 | high-side overtemperature flag, leg B |
| ls_fault_b | input | 1 | low-side overcurrent flag, leg B |
| supply_bad | input | 1 | supply under- or overvoltage flag |
| sense_dis | input | 1 | disables current sensing when high |
| dead_ticks | input | DW | dead delay in clock cycles |
| hs_a_on | output | 1 | high-side A command |
| hs_b_on | output | 1 | high-side B command |
| ls_a_on | output | 1 | low-side A command |
| ls_b_on | output | 1 | low-side B command |
| diag_a_pull | output | 1 | pull leg A diagnostic line low |
| diag_b_pull | output | 1 | pull leg B diagnostic line low |
| sense_en | output | 1 | current-sense output enable |

## Verification
The direction, PWM and enable inputs pass through two flops, so a change driven before edge k is seen at the outputs after edge k+1. A mode change also registers as pending at edge k+2, and the new mode is applied at edge k+3+dead_ticks. Fault flags and supply_bad act at the edge that samples them. sense_dis acts at once. The bench drives every input on a falling edge and counts rising edges up to the exact edge at which a result is due. It samples on the following falling edge, and it samples the dead window both on its last off cycle and on its first new cycle. The static sweep waits dead_ticks+6 edges before it compares, which is longer than any of these latencies.

// File: rtl/hbridge_ctl.sv
module hbridge_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_a,
  input  logic          dir_b,
  input  logic          pwm_in,
  input  logic          en_a_in,
  input  logic          en_b_in,
  input  logic          hs_fault_a,
  input  logic          ls_fault_a,
  input  logic          hs_fault_b,
  input  logic          ls_fault_b,
  input  logic          supply_bad,
  input  logic          sense_dis,
  input  logic [DW-1:0] dead_ticks,
  output logic          hs_a_on,
  output logic          hs_b_on,
  output logic          ls_a_on,
  output logic          ls_b_on,
  output logic          diag_a_pull,
  output logic          diag_b_pull,
  output logic          sense_en
);
  localparam int NS = 5;
  localparam int NL = 2;

  logic [NS-1:0] raw, s1, s2, s3;
  logic [NL-1:0] dir_s, en_s, rise, fin, flt, hs, ls, req, cur;
  logic          pwm_s, busy, sup_r;
  logic [DW-1:0] cnt;

  assign raw   = {en_b_in, en_a_in, pwm_in, dir_b, dir_a};
  assign dir_s = s2[1:0];
  assign pwm_s = s2[2];
  assign en_s  = s2[4:3];
  assign rise  = s2[1:0] & ~s3[1:0];
  assign fin   = {hs_fault_b | ls_fault_b, hs_fault_a | ls_fault_a};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      s3 <= s2;
    end

  // mode change: reload the dead counter, keep everything off until it expires
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req   <= '0;
      cur   <= '0;
      cnt   <= '0;
      busy  <= 1'b1;
      sup_r <= 1'b0;
    end else begin
      sup_r <= supply_bad;
      if (dir_s != req) begin
        req  <= dir_s;
        cnt  <= dead_ticks;
        busy <= 1'b1;
      end else if (busy) begin
        if (cnt == '0) begin
          cur  <= req;
          busy <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end

  for (genvar i = 0; i < NL; i++) begin : g_leg
    logic run;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        flt[i] <= 1'b0;
      else if (fin[i])
        flt[i] <= 1'b1;
      else if (rise[i])
        flt[i] <= 1'b0;

    assign run   = ~busy & ~sup_r & en_s[i] & ~flt[i];
    assign hs[i] = run & cur[i];
    assign ls[i] = run & ~cur[i] & pwm_s;
  end

  assign hs_a_on     = hs[0];
  assign hs_b_on     = hs[1];
  assign ls_a_on     = ls[0];
  assign ls_b_on     = ls[1];
  assign diag_a_pull = flt[0];
  assign diag_b_pull = flt[1];
  assign sense_en    = ~sense_dis & ~busy & (cur[0] ^ cur[1]);
endmodule

// File: rtl/hbridge_ctl_chk.sv
module hbridge_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic pwm_in,
  input logic hs_fault_a,
  input logic ls_fault_a,
  input logic supply_bad,
  input logic sense_dis,
  input logic hs_a_on,
  input logic hs_b_on,
  input logic ls_a_on,
  input logic ls_b_on,
  input logic diag_a_pull,
  input logic diag_b_pull,
  input logic sense_en
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !(hs_a_on | hs_b_on | ls_a_on | ls_b_on | diag_a_pull | diag_b_pull | sense_en));

  // R3
  pwm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwm_in, 2) |-> !(ls_a_on | ls_b_on));

  // R5
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_a_pull |-> !(hs_a_on | ls_a_on));

  // R5
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(diag_a_pull) |-> $past(hs_fault_a | ls_fault_a));

  // R8
  sense_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sense_en |-> !sense_dis);

  // R9
  supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(supply_bad) |-> !(hs_a_on | hs_b_on | ls_a_on | ls_b_on));

  // R10
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_a_on & ls_a_on) && !(hs_b_on & ls_b_on));
endmodule

bind hbridge_ctl hbridge_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .hs_fault_a(hs_fault_a),
  .ls_fault_a(ls_fault_a), .supply_bad(supply_bad), .sense_dis(sense_dis),
  .hs_a_on(hs_a_on), .hs_b_on(hs_b_on), .ls_a_on(ls_a_on), .ls_b_on(ls_b_on),
  .diag_a_pull(diag_a_pull), .diag_b_pull(diag_b_pull), .sense_en(sense_en)
);

// File: tb/tb_hbridge_ctl.sv
module tb_hbridge_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic dir_a = 0, dir_b = 0, pwm_in = 0, en_a_in = 0, en_b_in = 0;
  logic hs_fault_a = 0, ls_fault_a = 0, hs_fault_b = 0, ls_fault_b = 0;
  logic supply_bad = 0, sense_dis = 0;
  logic [DW-1:0] dead_ticks = 8'd1;
  logic hs_a_on, hs_b_on, ls_a_on, ls_b_on, diag_a_pull, diag_b_pull, sense_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_ctl #(.DW(DW)) dut (.*);

  // {sense, diag_b, diag_a, ls_b, ls_a, hs_b, hs_a}
  function automatic logic [6:0] outs();
    return {sense_en, diag_b_pull, diag_a_pull, ls_b_on, ls_a_on, hs_b_on, hs_a_on};
  endfunction

  function automatic logic [6:0] model(input logic a, b, p, ea, eb, sd, fa, fb);
    logic oka, okb;
    oka = ea & ~fa;
    okb = eb & ~fb;
    return {~sd & (a ^ b), fb, fa, okb & ~b & p, oka & ~a & p, okb & b, oka & a};
  endfunction

  task automatic chk(input string req, input logic [6:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    cycles(3);
    chk("R1 in reset", outs(), 7'b0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 after release", outs(), 7'b0);
    pwm_in = 1;
    en_a_in = 1;
    en_b_in = 1;
    cycles(8);

    // R2 R3 R4 R8: sweep mode, pwm, enables, sense_dis
    for (int m = 0; m < 4; m++)
      for (int v = 0; v < 16; v++) begin
        dir_a = m[1];
        dir_b = m[0];
        pwm_in = v[0];
        en_a_in = v[1];
        en_b_in = v[2];
        sense_dis = v[3];
        cycles(int'(dead_ticks) + 6);
        chk("R2/R3/R4/R8 sweep", outs(),
            model(dir_a, dir_b, pwm_in, en_a_in, en_b_in, sense_dis, 1'b0, 1'b0));
      end
    pwm_in = 1;
    en_a_in = 1;
    en_b_in = 1;
    sense_dis = 0;

    // R7: dead window with several counts
    for (int d = 0; d < 4; d++) begin
      dead_ticks = DW'(d * 2);
      dir_a = 0;
      dir_b = 0;
      cycles(d * 2 + 6);
      dir_a = 1;
      cycles(3 + d * 2);
      chk("R7 window off", outs(), 7'b0);
      cycles(1);
      chk("R7 new mode", outs(), model(1, 0, 1, 1, 1, 0, 0, 0));
    end
    dead_ticks = 8'd2;

    // R5 R6: leg A fault in mode 10
    hs_fault_a = 1;
    cycles(1);
    hs_fault_a = 0;
    chk("R5 latch A", outs(), model(1, 0, 1, 1, 1, 0, 1, 0));
    cycles(10);
    chk("R6 hold after flag drop", outs(), model(1, 0, 1, 1, 1, 0, 1, 0));
    dir_a = 0;
    cycles(10);
    chk("R6 fall keeps latch", outs(), model(0, 0, 1, 1, 1, 0, 1, 0));
    dir_b = 1;
    cycles(10);
    chk("R6 other leg edge keeps latch", outs(), model(0, 1, 1, 1, 1, 0, 1, 0));
    dir_b = 0;
    dir_a = 1;
    cycles(10);
    chk("R6 rise clears", outs(), model(1, 0, 1, 1, 1, 0, 0, 0));

    // R5: leg B fault through low-side flag
    ls_fault_b = 1;
    cycles(1);
    ls_fault_b = 0;
    chk("R5 latch B", outs(), model(1, 0, 1, 1, 1, 0, 0, 1));
    dir_b = 1;
    cycles(10);
    chk("R6 rise clears B", outs(), model(1, 1, 1, 1, 1, 0, 0, 0));
    dir_b = 0;
    cycles(10);

    // R9: supply flag
    supply_bad = 1;
    cycles(1);
    chk("R9 supply off", outs() & 7'b0001111, 7'b0);
    supply_bad = 0;
    cycles(1);
    chk("R9 supply back", outs(), model(1, 0, 1, 1, 1, 0, 0, 0));

    // R10: leg exclusivity at outputs across all modes with pwm high
    for (int m = 0; m < 4; m++) begin
      dir_a = m[1];
      dir_b = m[0];
      cycles(8);
      chk("R10 leg exclusive", {5'b0, hs_a_on & ls_a_on, hs_b_on & ls_b_on}, 7'b0);
    end
    finish_run();
  end
endmodule